// File: doc/BRIEF.md
# Shared Work RAM Bank Mapper

This block sits between two processors (A and B) and a work RAM made of two equal halves. A 2-bit mode field, held in a 16-bit control register, decides who owns the halves. One processor can own both, or each can own one half, in either order. Every access from either processor is turned into a bank, a word index and a set of byte lanes. Addresses above the allotted window wrap around, so a smaller window repeats across the address range.

Processor A also has a private RAM. Its accesses go there when the upper address bit is set, or when it owns no shared half. Processor B has no such fallback. When B owns nothing, its accesses are dropped and it sees a one-cycle error pulse. Both ports can access in the same cycle with no stall. Read data appears one clock after the request.

Top module: `wram_mapper`

## Requirements
- R1: After reset the control register reads 0x0300. That is mode 3: A owns both halves (shared bytes 0..511 at A addresses 0..511) and B owns none.
- R2: In mode 0, B owns both halves (B address bits [8:0] give the shared byte). Every A access goes to A's private RAM.
- R3: In mode 1, A maps to the lower half (shared bytes 0..255) and B maps to the upper half (256..511). Mode 2 swaps the two halves. In both modes the half is chosen by the mode and address bit 8 is ignored.
- R4: Within a window, the offset is the address masked by the window size minus one, so a half window mirrors. Halfword accesses clear address bit 0. Word accesses clear bits 1:0.
- R5: An A access with address bit 9 set, or in mode 0, goes to a 512-byte private RAM, offset addr[8:0] (aligned).
- R6: In mode 3, B accesses are unmapped. Writes change nothing, reads return zero, and bErr is high for exactly the one cycle after each unmapped access.
- R7: A control write stores wdata & 0x9F03. The mode is stored bits [9:8].
- R8: A control write changes the mapping from the next cycle on. Accesses in the same cycle use the old mode. RAM contents survive remapping.
- R9: Size codes are 0 = byte, 1 = halfword, 2 or 3 = word. A write updates only the addressed byte lanes. Read data is right-aligned and zero-extended, and is valid one cycle after the request.
- R10: A and B may access in the same cycle and both complete. Neither corrupts the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Control register write strobe |
| cfgWdata | input | 16 | Control write data |
| cfgRdata | output | 16 | Control register contents |
| aValid | input | 1 | Processor A access request |
| aWe | input | 1 | Processor A write |
| aSize | input | 2 | Processor A access size |
| aAddr | input | 10 | Processor A byte address (bit 9 = private region) |
| aWdata | input | 32 | Processor A write data, right-aligned |
| aRdata | output | 32 | Processor A read data |
| bValid | input | 1 | Processor B access request |
| bWe | input | 1 | Processor B write |
| bSize | input | 2 | Processor B access size |
| bAddr | input | 9 | Processor B byte address |
| bWdata | input | 32 | Processor B write data, right-aligned |
| bRdata | output | 32 | Processor B read data |
| bErr | output | 1 | Unmapped-access pulse for B |

## Verification
A wrong mode decode, or a wrong half assignment, sends a write to a byte the other processor or a later mode reads back. The error therefore shows up as wrong read data on a following read, often many cycles later, after a remap. Lane-mask or alignment faults show up at once, on the next read of the same word. An unmapped-handling fault shows as a missing or extra bErr pulse in the cycle after the access. It also shows as non-zero read data there, or as a shared byte changed by B's dropped write.

// File: rtl/wmap_pkg.sv
package wmap_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } accSize_e;

  typedef struct packed {
    logic     rdReq;     // raw read request, before mapping
    logic     rd;        // mapped read
    logic     wr;        // mapped write
    logic     toPriv;    // target is the private RAM
    logic     bank;      // shared half selected
    logic     unmapped;  // access falls outside any window
    logic [1:0] laneOff; // aligned byte offset inside the word
    accSize_e size;
  } portStrobe_t;

  localparam logic [15:0] CFG_KEEP  = 16'h9F03;
  localparam logic [15:0] CFG_RESET = 16'h0300;
endpackage

// File: rtl/wmap_ctrl.sv
module wmap_ctrl
  import wmap_pkg::*;
#(
  parameter int HALF_WORDS = 64,
  parameter int PRIV_WORDS = 128
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgWe,
  input  logic [15:0] cfgWdata,
  output logic [15:0] cfgRdata,
  input  logic aValid,
  input  logic aWe,
  input  logic [1:0] aSize,
  input  logic [$clog2(HALF_WORDS*4)+1 > $clog2(PRIV_WORDS*4) ? $clog2(HALF_WORDS*4)+1 : $clog2(PRIV_WORDS*4) : 0] aAddr,
  input  logic bValid,
  input  logic bWe,
  input  logic [1:0] bSize,
  input  logic [$clog2(HALF_WORDS*4):0] bAddr,
  output portStrobe_t stA,
  output portStrobe_t stB,
  output logic [($clog2(HALF_WORDS) > $clog2(PRIV_WORDS) ? $clog2(HALF_WORDS) : $clog2(PRIV_WORDS))-1:0] ixA,
  output logic [($clog2(HALF_WORDS) > $clog2(PRIV_WORDS) ? $clog2(HALF_WORDS) : $clog2(PRIV_WORDS))-1:0] ixB
);
  localparam int SH_AW  = $clog2(HALF_WORDS*4) + 1;
  localparam int PV_AW  = $clog2(PRIV_WORDS*4);
  localparam int ADDR_W = (SH_AW > PV_AW ? SH_AW : PV_AW) + 1;
  localparam int HIDX   = $clog2(HALF_WORDS);
  localparam int PIDX   = $clog2(PRIV_WORDS);
  localparam int IX_W   = HIDX > PIDX ? HIDX : PIDX;

  logic [15:0] cfgReg;
  logic [1:0]  mode;

  always_ff @(posedge clk) begin
    if (!rstN)      cfgReg <= CFG_RESET;
    else if (cfgWe) cfgReg <= cfgWdata & CFG_KEEP;
  end

  assign mode     = cfgReg[9:8];
  assign cfgRdata = cfgReg;

  function automatic portStrobe_t decode(
    input logic isA, input logic [1:0] m, input logic v, input logic we,
    input logic [1:0] sz, input logic [ADDR_W-1:0] ad, output logic [IX_W-1:0] ix);
    portStrobe_t s;
    logic full, none, hsel, unm;
    logic [ADDR_W-1:0] alAd;
    s = '0;
    ix = '0;
    unm = 1'b0;
    if (isA) begin
      full = (m == 2'd3); none = (m == 2'd0); hsel = (m == 2'd2);
    end else begin
      full = (m == 2'd0); none = (m == 2'd3); hsel = (m == 2'd1);
    end
    case (sz)
      2'd0:    alAd = ad;
      2'd1:    alAd = ad & ~ADDR_W'(1);
      default: alAd = ad & ~ADDR_W'(3);
    endcase
    s.size    = accSize_e'(sz);
    s.laneOff = alAd[1:0];
    if (isA && (ad[ADDR_W-1] || none)) begin
      s.toPriv = 1'b1;
      ix = IX_W'(alAd[PV_AW-1:2]);
    end else if (none) begin
      unm = 1'b1;
    end else if (full) begin
      s.bank = alAd[SH_AW-1];
      ix = IX_W'(alAd[SH_AW-2:2]);
    end else begin
      s.bank = hsel;
      ix = IX_W'(alAd[SH_AW-2:2]);
    end
    s.rdReq    = v & ~we;
    s.rd       = v & ~we & ~unm;
    s.wr       = v & we & ~unm;
    s.unmapped = v & unm;
    return s;
  endfunction

  always_comb stA = decode(1'b1, mode, aValid, aWe, aSize, aAddr, ixA);
  always_comb stB = decode(1'b0, mode, bValid, bWe, bSize, ADDR_W'(bAddr), ixB);

  // R7: stored value is the masked write data
  assert_cfg_mask_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> cfgRdata == ($past(cfgWdata) & 16'h9F03));
  // R10: the two ports never meet in one shared bank
  assert_no_bank_clash_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((stA.rd || stA.wr) && !stA.toPriv && (stB.rd || stB.wr)) |-> (stA.bank != stB.bank));
  // R6: B is only unmapped while A holds everything
  assert_b_unmapped_mode_R6: assert property (@(posedge clk) disable iff (!rstN)
    stB.unmapped |-> (cfgRdata[9:8] == 2'd3));
  // R2: in mode 0 every A access lands in private RAM
  assert_a_private_mode0_R2: assert property (@(posedge clk) disable iff (!rstN)
    (aValid && cfgRdata[9:8] == 2'd0) |-> stA.toPriv);
endmodule

// File: rtl/wmap_datapath.sv
module wmap_datapath
  import wmap_pkg::*;
#(
  parameter int HALF_WORDS = 64,
  parameter int PRIV_WORDS = 128
) (
  input  logic clk,
  input  logic rstN,
  input  portStrobe_t stA,
  input  portStrobe_t stB,
  input  logic [($clog2(HALF_WORDS) > $clog2(PRIV_WORDS) ? $clog2(HALF_WORDS) : $clog2(PRIV_WORDS))-1:0] ixA,
  input  logic [($clog2(HALF_WORDS) > $clog2(PRIV_WORDS) ? $clog2(HALF_WORDS) : $clog2(PRIV_WORDS))-1:0] ixB,
  input  logic [31:0] wdA,
  input  logic [31:0] wdB,
  output logic [31:0] rdA,
  output logic [31:0] rdB,
  output logic errB
);
  localparam int HIDX = $clog2(HALF_WORDS);
  localparam int PIDX = $clog2(PRIV_WORDS);
  localparam int IX_W = HIDX > PIDX ? HIDX : PIDX;
  localparam int NPORT = 2;

  logic [31:0] shMem [2][HALF_WORDS];
  logic [31:0] pvMem [PRIV_WORDS];

  portStrobe_t     st [NPORT];
  logic [IX_W-1:0] ix [NPORT];
  logic [31:0]     wd [NPORT];
  logic [31:0]     rdOut [NPORT];

  assign st[0] = stA;  assign st[1] = stB;
  assign ix[0] = ixA;  assign ix[1] = ixB;
  assign wd[0] = wdA;  assign wd[1] = wdB;
  assign rdA = rdOut[0];
  assign rdB = rdOut[1];

  function automatic logic [31:0] mergeLanes(input logic [31:0] old,
                                             input logic [31:0] w, input portStrobe_t s);
    logic [31:0] rep, res;
    logic [3:0]  msk;
    case (s.size)
      SZ_BYTE: begin rep = {4{w[7:0]}};  msk = 4'b0001 << s.laneOff; end
      SZ_HALF: begin rep = {2{w[15:0]}}; msk = 4'b0011 << s.laneOff; end
      default: begin rep = w;            msk = 4'b1111; end
    endcase
    for (int i = 0; i < 4; i++) res[8*i +: 8] = msk[i] ? rep[8*i +: 8] : old[8*i +: 8];
    return res;
  endfunction

  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORT; p++) begin
      if (st[p].wr) begin
        if (st[p].toPriv)
          pvMem[ix[p][PIDX-1:0]] <= mergeLanes(pvMem[ix[p][PIDX-1:0]], wd[p], st[p]);
        else
          shMem[st[p].bank][ix[p][HIDX-1:0]] <=
            mergeLanes(shMem[st[p].bank][ix[p][HIDX-1:0]], wd[p], st[p]);
      end
    end
  end

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_rdport
      logic [31:0] raw, shifted;
      logic [1:0]  off;
      accSize_e    sz;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          raw <= '0; off <= '0; sz <= SZ_WORD;
        end else if (st[p].rd) begin
          raw <= st[p].toPriv ? pvMem[ix[p][PIDX-1:0]] : shMem[st[p].bank][ix[p][HIDX-1:0]];
          off <= st[p].laneOff;
          sz  <= st[p].size;
        end else if (st[p].unmapped && st[p].rdReq) begin
          raw <= '0; off <= '0; sz <= SZ_WORD;
        end
      end
      always_comb begin
        shifted = raw >> {off, 3'b000};
        case (sz)
          SZ_BYTE: rdOut[p] = {24'd0, shifted[7:0]};
          SZ_HALF: rdOut[p] = {16'd0, shifted[15:0]};
          default: rdOut[p] = raw;
        endcase
      end
      // R9: byte reads come back zero-extended
      assert_byte_zero_ext_R9: assert property (@(posedge clk) disable iff (!rstN)
        (st[p].rd && st[p].size == SZ_BYTE) |=> (rdOut[p][31:8] == 24'd0));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) errB <= 1'b0;
    else       errB <= st[1].unmapped;
  end

  // R6: an unmapped read of B returns zero
  assert_unmapped_read_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (st[1].unmapped && st[1].rdReq) |=> (rdOut[1] == 32'd0));
  // R5: A always has somewhere to go
  assert_a_always_mapped_R5: assert property (@(posedge clk) disable iff (!rstN)
    !st[0].unmapped);
endmodule

// File: rtl/wram_mapper.sv
module wram_mapper
  import wmap_pkg::*;
#(
  parameter int HALF_WORDS = 64,
  parameter int PRIV_WORDS = 128,
  localparam int SH_AW  = $clog2(HALF_WORDS*4) + 1,
  localparam int PV_AW  = $clog2(PRIV_WORDS*4),
  localparam int ADDR_W = (SH_AW > PV_AW ? SH_AW : PV_AW) + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [15:0] cfgWdata,
  output logic [15:0] cfgRdata,
  input  logic        aValid,
  input  logic        aWe,
  input  logic [1:0]  aSize,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [31:0] aWdata,
  output logic [31:0] aRdata,
  input  logic        bValid,
  input  logic        bWe,
  input  logic [1:0]  bSize,
  input  logic [SH_AW-1:0] bAddr,
  input  logic [31:0] bWdata,
  output logic [31:0] bRdata,
  output logic        bErr
);
  localparam int HIDX = $clog2(HALF_WORDS);
  localparam int PIDX = $clog2(PRIV_WORDS);
  localparam int IX_W = HIDX > PIDX ? HIDX : PIDX;

  portStrobe_t stA, stB;
  logic [IX_W-1:0] ixA, ixB;

  wmap_ctrl #(.HALF_WORDS(HALF_WORDS), .PRIV_WORDS(PRIV_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .aValid(aValid), .aWe(aWe), .aSize(aSize), .aAddr(aAddr),
    .bValid(bValid), .bWe(bWe), .bSize(bSize), .bAddr(bAddr),
    .stA(stA), .stB(stB), .ixA(ixA), .ixB(ixB));

  wmap_datapath #(.HALF_WORDS(HALF_WORDS), .PRIV_WORDS(PRIV_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .stA(stA), .stB(stB), .ixA(ixA), .ixB(ixB),
    .wdA(aWdata), .wdB(bWdata), .rdA(aRdata), .rdB(bRdata), .errB(bErr));
endmodule

// File: tb/sim_wram_mapper.sv
module sim_wram_mapper;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 0; logic [15:0] cfgWdata = 0; logic [15:0] cfgRdata;
  logic aValid = 0, aWe = 0; logic [1:0] aSize = 0; logic [9:0] aAddr = 0;
  logic [31:0] aWdata = 0, aRdata;
  logic bValid = 0, bWe = 0; logic [1:0] bSize = 0; logic [8:0] bAddr = 0;
  logic [31:0] bWdata = 0, bRdata;
  logic bErr;

  int tests = 0, fails = 0;
  int mode = 3;
  logic [15:0] cfgModel = 16'h0300;
  byte unsigned sh [512];
  byte unsigned pv [512];

  always #4 clk = ~clk;

  wram_mapper u0 (.clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .aValid(aValid), .aWe(aWe), .aSize(aSize), .aAddr(aAddr), .aWdata(aWdata), .aRdata(aRdata),
    .bValid(bValid), .bWe(bWe), .bSize(bSize), .bAddr(bAddr), .bWdata(bWdata), .bRdata(bRdata),
    .bErr(bErr));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  function automatic int alignOf(int ad, int sz);
    return sz == 0 ? ad : (sz == 1 ? (ad & ~1) : (ad & ~3));
  endfunction
  function automatic int nBytes(int sz);
    return sz == 0 ? 1 : (sz == 1 ? 2 : 4);
  endfunction
  // location: -1 unmapped, 0..511 shared byte, 1000+n private byte
  function automatic int locA(int m, int ad);
    if (((ad >> 9) & 1) == 1 || m == 0) return 1000 + (ad & 511);
    if (m == 3) return ad & 511;
    if (m == 1) return ad & 255;
    return 256 + (ad & 255);
  endfunction
  function automatic int locB(int m, int ad);
    if (m == 3) return -1;
    if (m == 0) return ad & 511;
    if (m == 1) return 256 + (ad & 255);
    return ad & 255;
  endfunction
  function automatic logic [31:0] rdModel(int loc, int sz);
    logic [31:0] v = 0;
    if (loc < 0) return 0;
    for (int k = 0; k < nBytes(sz); k++)
      v[8*k +: 8] = (loc >= 1000) ? pv[loc - 1000 + k] : sh[loc + k];
    return v;
  endfunction
  task automatic wrModel(int loc, int sz, logic [31:0] d);
    if (loc < 0) return;
    for (int k = 0; k < nBytes(sz); k++)
      if (loc >= 1000) pv[loc - 1000 + k] = d[8*k +: 8];
      else sh[loc + k] = d[8*k +: 8];
  endtask
  function automatic string autoTag(int loc, int sz, int m);
    if (loc < 0) return "R6";
    if (loc >= 1000) return "R5";
    if (sz < 2) return "R9";
    if (m == 0) return "R2";
    if (m != 3) return "R3";
    return "R10";
  endfunction

  // one bus cycle; entered and left at a negative edge
  task automatic step(input bit cw, input logic [15:0] cd,
                      input bit av, input bit aw, input int asz, input int aad, input logic [31:0] awd,
                      input bit bv, input bit bw, input int bsz, input int bad, input logic [31:0] bwd,
                      input string tagA = "", input string tagB = "");
    int la, lb;
    logic [31:0] expA, expB;
    bit chkA, chkB, expErr;
    cfgWe = cw; cfgWdata = cd;
    aValid = av; aWe = aw; aSize = 2'(asz); aAddr = 10'(aad); aWdata = awd;
    bValid = bv; bWe = bw; bSize = 2'(bsz); bAddr = 9'(bad); bWdata = bwd;
    la = locA(mode, alignOf(aad & 1023, asz));
    lb = locB(mode, alignOf(bad & 511, bsz));
    if (lb >= 0) lb = alignOf(lb, bsz);
    if (la >= 0) la = (la >= 1000) ? 1000 + alignOf(la - 1000, asz) : alignOf(la, asz);
    chkA = av && !aw; chkB = bv && !bw;
    expA = rdModel(la, asz); expB = rdModel(lb, bsz);
    expErr = bv && (lb < 0);
    if (tagA == "") tagA = autoTag(la, asz, mode);
    if (tagB == "") tagB = autoTag(lb, bsz, mode);
    if (av && aw) wrModel(la, asz, awd);
    if (bv && bw) wrModel(lb, bsz, bwd);
    if (cw) begin cfgModel = cd & 16'h9F03; mode = int'(cfgModel[9:8]); end
    @(posedge clk); @(negedge clk);
    cfgWe = 0; aValid = 0; bValid = 0;
    if (chkA) check({tagA, " A read"}, aRdata, expA);
    if (chkB) check({tagB, " B read"}, bRdata, expB);
    check(expErr ? "R6 bErr pulse" : "R6 bErr idle", {31'd0, bErr}, {31'd0, expErr});
    if (cw) check("R7 cfg readback", {16'd0, cfgRdata}, {16'd0, cfgModel});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 cfg reset", {16'd0, cfgRdata}, 32'h0000_0300);
    check("R1 bErr reset", {31'd0, bErr}, 32'd0);
    check("R1 aRdata reset", aRdata, 32'd0);

    // fill shared (mode 3, A owns all) and private RAM
    for (int i = 0; i < 128; i++)
      step(0, 0, 1, 1, 2, i * 4, $urandom, 0, 0, 0, 0, 0);
    for (int i = 0; i < 128; i++)
      step(0, 0, 1, 1, 2, 512 + i * 4, $urandom, 0, 0, 0, 0, 0);

    // R6: B unmapped in mode 3
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 2, 0, 0, "", "R6");
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 2, 4, 32'hDEAD_BEEF, "", "R6");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R1: A sees full window
    step(0, 0, 1, 0, 2, 'h1FC, 0, 0, 0, 0, 0, 0, "R1");
    // R7: masking
    step(1, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R7 mask value", {16'd0, cfgRdata}, 32'h0000_9F03);
    // R8: same-cycle access uses old mode, then R4 mirroring under mode 1
    step(1, 16'h0100, 1, 0, 2, 'h104, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 1, 0, 2, 'h104, 0, 1, 0, 2, 'h004, 0, "R4", "R3");
    step(0, 0, 1, 0, 2, 'h004, 0, 1, 0, 2, 'h104, 0, "R4", "R3");
    // R9: lanes
    step(0, 0, 1, 1, 0, 'h009, 32'h0000_00A5, 1, 1, 1, 'h00E, 32'h0000_5A3C, "R9", "R9");
    step(0, 0, 1, 0, 2, 'h008, 0, 1, 0, 2, 'h00C, 0, "R9", "R9");
    step(0, 0, 1, 0, 1, 'h00B, 0, 1, 0, 0, 'h00F, 0, "R9", "R9");
    // mode 2, then mode 0; R8 contents survive
    step(1, 16'h0200, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 2, 'h008, 0, 1, 0, 2, 'h108, 0, "R3", "R8");
    step(1, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 2, 'h010, 0, 1, 0, 2, 'h004, 0, "R5", "R2");
    step(0, 0, 1, 1, 2, 'h020, 32'h1234_5678, 1, 1, 2, 'h1F0, 32'hCAFE_F00D, "R2", "R10");
    step(0, 0, 1, 0, 2, 'h220, 0, 1, 0, 2, 'h1F0, 0, "R5", "R10");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit cw = ($urandom % 40) == 0;
      step(cw, 16'($urandom),
           ($urandom % 4) != 0, $urandom % 2, $urandom % 3, $urandom % 1024, $urandom,
           ($urandom % 4) != 0, $urandom % 2, $urandom % 3, $urandom % 512, $urandom);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule